// File: doc/BRIEF.md
# Paged RAM Expansion Bank Controller

This block sits beside an 8-bit CPU that uses a 16-bit address. It watches I/O writes for a RAM configuration command and keeps a 3-bit configuration code. On each memory access it looks at the two top address bits, which pick one of four 16 KB windows. It then decides whether that window is served by an internal bank or an external bank.

When a read goes to an external bank, the block raises a read-disable line. The external memory then drives the CPU data bus, and the output of the internal RAM is kept off that bus. When a write goes to an external bank, the block holds back the internal write-enable and the internal data-in buffer enable, and the external RAM captures the data. The block never uses read-disable to protect internal RAM from a write. The column strobe to internal RAM is gated in the same way.

For external accesses the block gives the external bank number minus four and an active-low chip select. For internal accesses it gives the internal bank number. Every output is registered and reflects the access presented one clock earlier.

Top module: `ram_page_ctrl`

## Requirements
- R1: While reset is high and after it is released, the configuration code is 0 and the outputs are idle: rd_dis=0, int_we=0, int_din_en=0, int_cas=0, ext_cs_n=1, ext_bank=0, int_page=0.
- R2: An I/O write (io_wr=1) with addr_hi[1]=0 (A15) and io_data[7:6]=2'b11 loads io_data[2:0] into the configuration code. addr_hi[0] has no effect on this.
- R3: An I/O write with A15=1, with io_data[7]=0, or with io_data[6]=0 leaves the configuration code unchanged.
- R4: With code 0, windows 00, 01, 10 and 11 (addr_hi) map to internal banks 0, 1, 2 and 3.
- R5: With code 1 the windows map to banks 0, 1, 2, 7. With code 3 they map to banks 0, 3, 2, 7.
- R6: With code 2 the windows map to external banks 4, 5, 6, 7, so no access reaches internal RAM.
- R7: With codes 4 to 7, window 01 maps to the bank equal to the code. Windows 00, 10 and 11 map to internal banks 0, 2 and 3.
- R8: A memory read (mem_rd=1) to an external bank gives rd_dis=1, ext_cs_n=0 and int_cas=0. A read to an internal bank gives rd_dis=0, ext_cs_n=1 and int_cas=1.
- R9: A memory write (mem_wr=1) to an external bank gives int_we=0 and int_din_en=0, with ext_cs_n=0. A write to an internal bank gives int_we=1, int_din_en=1 and int_cas=1. A write never raises rd_dis.
- R10: Outputs are registered. With no memory request in the previous cycle, the outputs are idle as described in R1.
- R11: ext_bank carries (bank - 4) for an external access and is 0 otherwise. int_page carries the bank number for an internal access and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_hi | input | 2 | CPU address bits A15:A14 |
| io_data | input | 8 | CPU data bus during an I/O write |
| io_wr | input | 1 | I/O write strobe |
| mem_rd | input | 1 | Memory read request |
| mem_wr | input | 1 | Memory write request |
| rd_dis | output | 1 | Blocks internal RAM read data from the CPU |
| int_we | output | 1 | Internal RAM write enable |
| int_din_en | output | 1 | Internal data-in buffer enable |
| int_cas | output | 1 | Internal column strobe gate |
| int_page | output | 2 | Internal bank number |
| ext_bank | output | 2 | External bank number minus four |
| ext_cs_n | output | 1 | External RAM chip select, active low |

## Verification
The hardest cases to reach are the ones where the configuration code must stay unchanged after a rejected command. That state can only be seen through the next memory access. So the stimulus first loads a known external code, then sends near-miss commands: A15 high, D7 low, or D6 low, each with a low nibble that would otherwise select a different code. It then reads window 01 and window 00 to see whether the mapping moved. Directed sweeps cover every code in every window for both reads and writes. Seeded random mixes of commands and accesses then exercise arbitrary orderings.

// File: rtl/ram_page_pkg.sv
package ram_page_pkg;
  localparam int CODE_W = 3;
  localparam int WIN_W  = 2;
  localparam int NWIN   = 1 << WIN_W;
  typedef logic [CODE_W-1:0] bank_t;

  // Bank served by window win under configuration code cfg.
  function automatic bank_t map_bank(input bank_t cfg, input logic [WIN_W-1:0] win);
    bank_t b;
    b = bank_t'(win);
    if (cfg[CODE_W-1]) begin
      if (win == 2'b01) b = cfg;
    end else begin
      case (cfg[1:0])
        2'd1: if (win == 2'b11) b = 3'd7;
        2'd2: b = {1'b1, win};
        2'd3: begin
          if (win == 2'b01) b = 3'd3;
          if (win == 2'b11) b = 3'd7;
        end
        default: b = bank_t'(win);
      endcase
    end
    return b;
  endfunction
endpackage

// File: rtl/cfg_port.sv
module cfg_port
  import ram_page_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic              a15,
  input  logic [DATA_W-1:0] io_data,
  output bank_t             cfg
);
  logic hit;
  logic unused_bits;
  logic past_ok;

  assign unused_bits = ^io_data[DATA_W-3:CODE_W];
  assign hit = io_wr && !a15 && (io_data[DATA_W-1:DATA_W-2] == 2'b11);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (hit) cfg <= io_data[CODE_W-1:0];
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && io_wr && !a15 && io_data[DATA_W-1] && io_data[DATA_W-2])
      |=> (cfg == $past(io_data[CODE_W-1:0])));

  assert_ignore_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && (!io_wr || a15 || !io_data[DATA_W-1] || !io_data[DATA_W-2]))
      |=> $stable(cfg));
endmodule

// File: rtl/bank_map.sv
module bank_map
  import ram_page_pkg::*;
(
  input  bank_t            cfg,
  input  logic [WIN_W-1:0] win,
  output bank_t            bank
);
  bank_t win_bank [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign win_bank[w] = map_bank(cfg, WIN_W'(w));
  end

  assign bank = win_bank[win];
endmodule

// File: rtl/access_gate.sv
module access_gate
  import ram_page_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  bank_t            bank,
  input  logic             mem_rd,
  input  logic             mem_wr,
  output logic             rd_dis,
  output logic             int_we,
  output logic             int_din_en,
  output logic             int_cas,
  output logic [WIN_W-1:0] int_page,
  output logic [WIN_W-1:0] ext_bank,
  output logic             ext_cs_n
);
  logic is_ext, req, past_ok;

  assign is_ext = bank[CODE_W-1];
  assign req    = mem_rd | mem_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_dis     <= 1'b0;
      int_we     <= 1'b0;
      int_din_en <= 1'b0;
      int_cas    <= 1'b0;
      int_page   <= '0;
      ext_bank   <= '0;
      ext_cs_n   <= 1'b1;
      past_ok    <= 1'b0;
    end else begin
      past_ok    <= 1'b1;
      rd_dis     <= mem_rd & is_ext;
      int_we     <= mem_wr & ~is_ext;
      int_din_en <= mem_wr & ~is_ext;
      int_cas    <= req & ~is_ext;
      ext_cs_n   <= ~(req & is_ext);
      int_page   <= (req & ~is_ext) ? bank[WIN_W-1:0] : '0;
      ext_bank   <= (req & is_ext)  ? bank[WIN_W-1:0] : '0;
    end
  end

  assert_rd_dis_ext_R8: assert property (@(posedge clk) disable iff (rst)
    rd_dis |-> (!ext_cs_n && !int_cas));

  assert_we_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(int_we && !ext_cs_n));

  assert_wr_no_dis_R9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && mem_wr && !mem_rd) |=> !rd_dis);

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !mem_rd && !mem_wr) |=> (ext_cs_n && !int_cas && !int_we && !rd_dis));
endmodule

// File: rtl/ram_page_ctrl.sv
module ram_page_ctrl
  import ram_page_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr_hi,
  input  logic [DATA_W-1:0] io_data,
  input  logic              io_wr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  output logic              rd_dis,
  output logic              int_we,
  output logic              int_din_en,
  output logic              int_cas,
  output logic [1:0]        int_page,
  output logic [1:0]        ext_bank,
  output logic              ext_cs_n
);
  bank_t cfg, bank;

  cfg_port #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .io_wr(io_wr), .a15(addr_hi[1]),
    .io_data(io_data), .cfg(cfg)
  );

  bank_map u_map (.cfg(cfg), .win(addr_hi), .bank(bank));

  access_gate u_gate (
    .clk(clk), .rst(rst), .bank(bank), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .rd_dis(rd_dis), .int_we(int_we), .int_din_en(int_din_en),
    .int_cas(int_cas), .int_page(int_page), .ext_bank(ext_bank),
    .ext_cs_n(ext_cs_n)
  );
endmodule

// File: tb/test_ram_page_ctrl.sv
`timescale 1ns/1ps
module test_ram_page_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] addr_hi = '0;
  logic [7:0] io_data = '0;
  logic io_wr = 1'b0, mem_rd = 1'b0, mem_wr = 1'b0;
  logic rd_dis, int_we, int_din_en, int_cas, ext_cs_n;
  logic [1:0] int_page, ext_bank;

  int checks = 0;
  int fails = 0;
  logic [2:0] model_cfg = 3'd0;

  always #4 clk = ~clk;

  ram_page_ctrl i_ram_page_ctrl (
    .clk(clk), .rst(rst), .addr_hi(addr_hi), .io_data(io_data), .io_wr(io_wr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .rd_dis(rd_dis), .int_we(int_we),
    .int_din_en(int_din_en), .int_cas(int_cas), .int_page(int_page),
    .ext_bank(ext_bank), .ext_cs_n(ext_cs_n)
  );

  function automatic logic [2:0] exp_bank(input logic [2:0] code, input logic [1:0] w);
    logic [2:0] t [4];
    case (code)
      3'd0: t = '{3'd0, 3'd1, 3'd2, 3'd3};
      3'd1: t = '{3'd0, 3'd1, 3'd2, 3'd7};
      3'd2: t = '{3'd4, 3'd5, 3'd6, 3'd7};
      3'd3: t = '{3'd0, 3'd3, 3'd2, 3'd7};
      default: t = '{3'd0, code, 3'd2, 3'd3};
    endcase
    return t[w];
  endfunction

  function automatic string tag_for(input logic [2:0] code);
    if (code == 3'd0) return "R4";
    if (code == 3'd2) return "R6";
    if (code[2]) return "R7";
    return "R5";
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Packed vector: rd_dis,int_we,int_din_en,int_cas,ext_cs_n,int_page,ext_bank
  function automatic logic [8:0] expect_vec(input logic rd, input logic wr, input logic [2:0] b);
    logic ext, rq;
    ext = b[2];
    rq = rd | wr;
    return {rd & ext, wr & ~ext, wr & ~ext, rq & ~ext, ~(rq & ext),
            (rq & ~ext) ? b[1:0] : 2'b00, (rq & ext) ? b[1:0] : 2'b00};
  endfunction

  function automatic logic [8:0] out_vec();
    return {rd_dis, int_we, int_din_en, int_cas, ext_cs_n, int_page, ext_bank};
  endfunction

  task automatic io_cycle(input logic [1:0] ah, input logic [7:0] d);
    @(negedge clk);
    addr_hi = ah; io_data = d; io_wr = 1'b1; mem_rd = 1'b0; mem_wr = 1'b0;
    if (!ah[1] && d[7] && d[6]) model_cfg = d[2:0];
    @(negedge clk);
    io_wr = 1'b0;
    check("R10", out_vec(), expect_vec(1'b0, 1'b0, 3'd0));
  endtask

  task automatic mem_cycle(input logic rd, input logic wr, input logic [1:0] ah, input string req);
    logic [2:0] b;
    @(negedge clk);
    addr_hi = ah; mem_rd = rd; mem_wr = wr; io_wr = 1'b0;
    b = exp_bank(model_cfg, ah);
    @(negedge clk);
    check(req, out_vec(), expect_vec(rd, wr, b));
    mem_rd = 1'b0; mem_wr = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1", out_vec(), expect_vec(1'b0, 1'b0, 3'd0));
    rst = 1'b0;
    @(negedge clk);
    check("R1", out_vec(), expect_vec(1'b0, 1'b0, 3'd0));
    mem_cycle(1'b1, 1'b0, 2'b01, "R1 reset code 0");

    // R4 R5 R6 R7 R8 R9 R11: every code in every window, read and write
    for (int c = 0; c < 8; c++) begin
      io_cycle(2'b00, 8'hC0 | 8'(c));
      for (int w = 0; w < 4; w++) begin
        mem_cycle(1'b1, 1'b0, 2'(w), {tag_for(3'(c)), " R8 R11 read"});
        mem_cycle(1'b0, 1'b1, 2'(w), {tag_for(3'(c)), " R9 R11 write"});
      end
    end

    // R2: A14 ignored by decode, D5..D3 ignored
    io_cycle(2'b01, 8'hFE);
    mem_cycle(1'b1, 1'b0, 2'b01, "R2 A14 high, code 6");
    // R3: near-miss commands leave code 6
    io_cycle(2'b10, 8'hC4);
    mem_cycle(1'b1, 1'b0, 2'b01, "R3 A15 high ignored");
    io_cycle(2'b00, 8'h45);
    mem_cycle(1'b1, 1'b0, 2'b01, "R3 D7 low ignored");
    io_cycle(2'b00, 8'h82);
    mem_cycle(1'b1, 1'b0, 2'b00, "R3 D6 low ignored");
    io_cycle(2'b11, 8'hC2);
    mem_cycle(1'b0, 1'b1, 2'b00, "R3 A15 high ignored write");
    mem_cycle(1'b0, 1'b0, 2'b01, "R10 idle");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [1:0] ah;
      logic [7:0] d;
      int op;
      ah = 2'($urandom);
      d = 8'($urandom);
      op = int'($urandom % 4);
      if (op == 0) begin
        if ($urandom % 2 == 1) d[7:6] = 2'b11;
        io_cycle(ah, d);
      end else if (op == 1) mem_cycle(1'b1, 1'b0, ah, "R2 R3 R8 random read");
      else if (op == 2) mem_cycle(1'b0, 1'b1, ah, "R2 R3 R9 random write");
      else mem_cycle(1'b0, 1'b0, ah, "R10 random idle");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule